// File: doc/BRIEF.md
# Double-Bank Block Buffer for Storage-Card Streaming

This block sits between an audio capture path and a storage-card serial writer. Sample words arrive through a valid/ready handshake and are packed byte by byte into one of two 512-byte banks. When a bank is full it is handed to the drain side, and the other bank starts filling. Capture can therefore go on while the card takes a whole block.

The drain side waits until the card reports that it is not busy. It then raises a chip-select request and streams the bank as one unbroken 512-byte block. Each byte goes out under its own valid/ready handshake, with start-of-block and end-of-block markers. The chip-select request stays up from before the first byte until after the last byte, even if the writer stalls. A mode input selects stereo packing (four bytes per sample word) or mono packing (two bytes per sample word).

A flush request pads a partly filled bank with zero bytes and sends it. If a sample arrives while both banks are still waiting for the card, that sample is discarded and a saturating overflow counter is incremented.

Top module: `pp_block_buffer`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, card_sel is 0 and ovf_count is 0.
- R2: In stereo mode (stereo_mode = 1), each accepted word yields four bytes, in_data[7:0] first and in_data[31:24] last, so one block holds 128 words.
- R3: In mono mode (stereo_mode = 0), each accepted word yields two bytes, in_data[7:0] then in_data[15:8]; in_data[31:16] is ignored, and one block holds 256 words.
- R4: Blocks leave in the order they were filled. Each block is exactly 512 bytes. out_sof is 1 only on the first byte of a block and out_eof is 1 only on the 512th byte.
- R5: card_sel is high whenever out_valid is high. Once raised, card_sel stays high until the cycle after the end-of-block byte is taken.
- R6: A block does not start while card_busy is 1. A change of card_busy during a block has no effect on that block.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_sof and out_eof hold their values.
- R8: A word accepted while both banks are full is discarded, and ovf_count goes up by one. ovf_count saturates at its maximum value and never decreases.
- R9: A flush pulse fills the rest of a partly filled bank with 0x00 bytes and sends it. A flush while the filling bank is empty has no effect. in_ready is 0 while a flush is pending.
- R10: A new value on stereo_mode takes effect only when both banks are empty and no block is in progress. A change made at any other time is ignored until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stereo_mode | input | 1 | 1 = four bytes per word, 0 = two bytes per word |
| in_valid | input | 1 | Sample word valid |
| in_ready | output | 1 | Sample word can be accepted |
| in_data | input | IN_W | Sample word |
| flush | input | 1 | Pad and send the partly filled bank |
| card_busy | input | 1 | Card cannot take a new block |
| card_sel | output | 1 | Chip-select request, held for a whole block |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Writer takes the byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a block |
| out_eof | output | 1 | Last byte of a block |
| ovf_count | output | OVF_W | Count of discarded words, saturating |

## Verification
The bench drives several input patterns, and each one separates a different kind of fault:

- **Stereo words with random gaps:** the writer stalls at random and the card reports busy at random between blocks. This pattern exposes wrong byte order, wrong bank order and faulty block markers.
- **Mono words with random upper halves:** a stereo-mode request is raised part way through. This shows whether the upper 16 bits are really ignored and whether a mode change outside the empty state is held back.
- **Back-to-back words with the card held busy:** the bench fills both banks and then offers three more words. This tells a discard with a count apart from a stall or an overwrite.
- **Flushes at a block boundary, in mid-block and on an empty buffer:** these separate correct zero padding from a spurious extra block.

// File: rtl/pp_block_buffer_pkg.sv
package pp_block_buffer_pkg;

  localparam int NUM_BANKS = 2;

  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_PACK = 2'd1,
    FILL_PAD  = 2'd2
  } fill_st_t;

  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,
    DR_START = 2'd1,
    DR_SHOW  = 2'd2
  } drain_st_t;

endpackage

// File: rtl/pp_bank_ram.sv
module pp_bank_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // write port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port with enable and sync reset of the output register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/pp_fill.sv
module pp_fill
  import pp_block_buffer_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int IN_W        = 32,
  parameter int OVF_W       = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_stereo,
  input  logic                 in_valid,
  input  logic [IN_W-1:0]      in_data,
  output logic                 in_ready,
  input  logic                 flush,
  input  logic [NUM_BANKS-1:0] bank_full,
  output logic                 set_full,
  output logic                 set_idx,
  output logic                 wr_en,
  output logic [$clog2(BLOCK_BYTES):0] wr_addr,
  output logic [7:0]           wr_data,
  output logic [OVF_W-1:0]     ovf_count,
  output logic                 fill_empty
);

  localparam int AW     = $clog2(BLOCK_BYTES);
  localparam int LANES  = IN_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [AW-1:0]     LAST_PTR    = AW'(BLOCK_BYTES - 1);
  localparam logic [LANE_W-1:0] LAST_STEREO = LANE_W'(LANES - 1);
  localparam logic [LANE_W-1:0] LAST_MONO   = LANE_W'(LANES / 2 - 1);
  localparam logic [OVF_W-1:0]  OVF_MAX     = {OVF_W{1'b1}};

  fill_st_t          state;
  logic              wr_bank;
  logic [AW-1:0]     wr_ptr;
  logic [LANE_W-1:0] lane_idx;
  logic [LANE_W-1:0] last_lane;
  logic [IN_W-1:0]   word_q;
  logic              flush_pend;
  logic [7:0]        lane [LANES];

  // byte lanes of the held word, lowest lane first
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_q[8*g +: 8];
  end

  assign in_ready   = (state == FILL_IDLE) && !flush_pend;
  assign wr_en      = (state != FILL_IDLE);
  assign wr_addr    = {wr_bank, wr_ptr};
  assign wr_data    = (state == FILL_PACK) ? lane[lane_idx] : 8'h00;
  assign set_full   = wr_en && (wr_ptr == LAST_PTR);
  assign set_idx    = wr_bank;
  assign fill_empty = (state == FILL_IDLE) && (wr_ptr == '0) && !flush_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= FILL_IDLE;
      wr_bank    <= 1'b0;
      wr_ptr     <= '0;
      lane_idx   <= '0;
      last_lane  <= '0;
      word_q     <= '0;
      flush_pend <= 1'b0;
      ovf_count  <= '0;
    end else begin
      case (state)
        FILL_IDLE: begin
          if (in_valid && in_ready) begin
            if (bank_full[wr_bank]) begin
              // both banks occupied: the word is discarded
              if (ovf_count != OVF_MAX) ovf_count <= ovf_count + 1'b1;
            end else begin
              word_q    <= in_data;
              lane_idx  <= '0;
              last_lane <= mode_stereo ? LAST_STEREO : LAST_MONO;
              state     <= FILL_PACK;
            end
          end else if (flush_pend) begin
            if (wr_ptr == '0) flush_pend <= 1'b0;
            else              state      <= FILL_PAD;
          end
        end
        FILL_PACK: begin
          lane_idx <= lane_idx + 1'b1;
          if (wr_ptr == LAST_PTR) begin
            wr_ptr  <= '0;
            wr_bank <= ~wr_bank;
            state   <= FILL_IDLE;
          end else begin
            wr_ptr <= wr_ptr + 1'b1;
            if (lane_idx == last_lane) state <= FILL_IDLE;
          end
        end
        FILL_PAD: begin
          if (wr_ptr == LAST_PTR) begin
            wr_ptr     <= '0;
            wr_bank    <= ~wr_bank;
            flush_pend <= 1'b0;
            state      <= FILL_IDLE;
          end else begin
            wr_ptr <= wr_ptr + 1'b1;
          end
        end
        default: state <= FILL_IDLE;
      endcase
      // a new flush request wins over the clear above
      if (flush) flush_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/pp_drain.sv
module pp_drain
  import pp_block_buffer_pkg::*;
#(
  parameter int BLOCK_BYTES = 512
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] bank_full,
  input  logic                 card_busy,
  output logic                 rd_en,
  output logic [$clog2(BLOCK_BYTES):0] rd_addr,
  input  logic [7:0]           rd_data,
  output logic                 clr_full,
  output logic                 clr_idx,
  output logic                 drain_idle,
  output logic                 card_sel,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_data,
  output logic                 out_sof,
  output logic                 out_eof
);

  localparam int AW = $clog2(BLOCK_BYTES);
  localparam logic [AW-1:0] LAST_PTR = AW'(BLOCK_BYTES - 1);

  drain_st_t     state;
  logic          rd_bank;
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] nxt_ptr;
  logic          is_last;
  logic          take;

  assign is_last    = (rd_ptr == LAST_PTR);
  assign take       = (state == DR_SHOW) && out_ready;
  assign nxt_ptr    = (state == DR_START) ? '0 : rd_ptr + 1'b1;
  assign rd_en      = (state == DR_START) || (take && !is_last);
  assign rd_addr    = {rd_bank, nxt_ptr};
  assign out_valid  = (state == DR_SHOW);
  assign out_data   = rd_data;
  assign out_sof    = (state == DR_SHOW) && (rd_ptr == '0);
  assign out_eof    = (state == DR_SHOW) && is_last;
  assign clr_full   = take && is_last;
  assign clr_idx    = rd_bank;
  assign drain_idle = (state == DR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= DR_IDLE;
      rd_bank  <= 1'b0;
      rd_ptr   <= '0;
      card_sel <= 1'b0;
    end else begin
      case (state)
        DR_IDLE: begin
          if (bank_full[rd_bank] && !card_busy) begin
            card_sel <= 1'b1;
            rd_ptr   <= '0;
            state    <= DR_START;
          end
        end
        DR_START: state <= DR_SHOW;
        DR_SHOW: begin
          if (out_ready) begin
            if (is_last) begin
              card_sel <= 1'b0;
              rd_bank  <= ~rd_bank;
              rd_ptr   <= '0;
              state    <= DR_IDLE;
            end else begin
              rd_ptr <= rd_ptr + 1'b1;
            end
          end
        end
        default: state <= DR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pp_block_buffer.sv
module pp_block_buffer
  import pp_block_buffer_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int IN_W        = 32,
  parameter int OVF_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stereo_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             flush,
  input  logic             card_busy,
  output logic             card_sel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic [OVF_W-1:0] ovf_count
);

  localparam int AW     = $clog2(BLOCK_BYTES);
  localparam int RAM_AW = AW + 1;

  logic [NUM_BANKS-1:0] bank_full;
  logic                 mode_q;
  logic                 set_full, set_idx, clr_full, clr_idx;
  logic                 wr_en, rd_en;
  logic [RAM_AW-1:0]    wr_addr, rd_addr;
  logic [7:0]           wr_data, rd_data;
  logic                 fill_empty, drain_idle;

  // bank occupancy flags: set by the filler, cleared by the drain
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_full <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (set_full && (set_idx == 1'(b)))      bank_full[b] <= 1'b1;
        else if (clr_full && (clr_idx == 1'(b))) bank_full[b] <= 1'b0;
      end
    end
  end

  // packing mode is adopted only when nothing is buffered
  always_ff @(posedge clk) begin
    if (rst)                                            mode_q <= 1'b0;
    else if (fill_empty && drain_idle && bank_full == '0) mode_q <= stereo_mode;
  end

  pp_fill #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .IN_W       (IN_W),
    .OVF_W      (OVF_W)
  ) u_fill (
    .clk        (clk),
    .rst        (rst),
    .mode_stereo(mode_q),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .flush      (flush),
    .bank_full  (bank_full),
    .set_full   (set_full),
    .set_idx    (set_idx),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ovf_count  (ovf_count),
    .fill_empty (fill_empty)
  );

  pp_bank_ram #(
    .DATA_W(8),
    .ADDR_W(RAM_AW)
  ) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wr_data),
    .re   (rd_en),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  pp_drain #(
    .BLOCK_BYTES(BLOCK_BYTES)
  ) u_drain (
    .clk       (clk),
    .rst       (rst),
    .bank_full (bank_full),
    .card_busy (card_busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .clr_full  (clr_full),
    .clr_idx   (clr_idx),
    .drain_idle(drain_idle),
    .card_sel  (card_sel),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );

endmodule

// File: rtl/pp_block_buffer_chk.sv
module pp_block_buffer_chk #(
  parameter int OVF_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             card_busy,
  input logic             card_sel,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_sof,
  input logic             out_eof,
  input logic [OVF_W-1:0] ovf_count
);

  assert_sel_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> card_sel);

  assert_sel_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (card_sel && !(out_valid && out_ready && out_eof)) |=> card_sel);

  assert_busy_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (!card_sel && card_busy) |=> !card_sel);

  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

  assert_marks_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_sof && out_eof));

  assert_block_end_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eof) |=> !out_valid);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_count >= $past(ovf_count));

endmodule

bind pp_block_buffer pp_block_buffer_chk #(.OVF_W(OVF_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .card_busy(card_busy),
  .card_sel (card_sel),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_sof  (out_sof),
  .out_eof  (out_eof),
  .ovf_count(ovf_count)
);

// File: tb/pp_block_buffer_tb.sv
module pp_block_buffer_tb;

  localparam int BLK   = 512;
  localparam int IN_W  = 32;
  localparam int OVF_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             stereo_mode = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [IN_W-1:0]  in_data = '0;
  logic             flush = 1'b0;
  logic             card_busy = 1'b0;
  logic             card_sel;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [7:0]       out_data;
  logic             out_sof;
  logic             out_eof;
  logic [OVF_W-1:0] ovf_count;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] exp_q[$];
  int         exp_t[$];
  int  fill_cnt   = 0;
  int  out_cnt    = 0;
  bit  model_mode = 1'b1;
  bit  model_drop = 1'b0;
  bit  sink_rand  = 1'b1;
  bit  man_ready  = 1'b1;
  bit  man_busy   = 1'b0;
  bit  done       = 1'b0;

  always #10 clk = ~clk;

  pp_block_buffer #(.BLOCK_BYTES(BLK), .IN_W(IN_W), .OVF_W(OVF_W)) u_dut (
    .clk(clk), .rst(rst), .stereo_mode(stereo_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .flush(flush), .card_busy(card_busy),
    .card_sel(card_sel), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof), .ovf_count(ovf_count)
  );

  function automatic string tag_name(int t);
    case (t)
      2:       return "R2";
      3:       return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_byte(logic [7:0] b, int t);
    exp_q.push_back(b);
    exp_t.push_back(t);
    fill_cnt = (fill_cnt + 1) % BLK;
  endtask

  // writer and card side: one driver for out_ready and card_busy
  always @(negedge clk) begin
    if (sink_rand) begin
      out_ready = ($urandom % 4) != 0;
      card_busy = ($urandom % 8) == 0;
    end else begin
      out_ready = man_ready;
      card_busy = man_busy;
    end
  end

  // monitor, sampled between the falling and the next rising edge
  always begin
    @(negedge clk);
    #5;
    if (!rst) begin
      if (in_valid && in_ready && !model_drop) begin
        if (model_mode) begin
          for (int k = 0; k < 4; k++) push_byte(in_data[8*k +: 8], 2);
        end else begin
          for (int k = 0; k < 2; k++) push_byte(in_data[8*k +: 8], 3);
        end
      end
      if (flush) begin
        while (fill_cnt != 0) push_byte(8'h00, 9);
      end
      if (out_valid && !card_sel) check(1'b0, "R5 sel during byte", 0, 1);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected byte", out_data, 0);
        end else begin
          logic [7:0] e;
          int t;
          e = exp_q.pop_front();
          t = exp_t.pop_front();
          check(out_data == e, tag_name(t), out_data, e);
          check(out_sof == ((out_cnt % BLK) == 0), "R4 sof", out_sof, (out_cnt % BLK) == 0);
          check(out_eof == ((out_cnt % BLK) == BLK-1), "R4 eof", out_eof, (out_cnt % BLK) == BLK-1);
        end
        out_cnt++;
      end
    end
  end

  task automatic send(logic [IN_W-1:0] d, int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    #5;
    while (!in_ready) begin
      @(negedge clk);
      #5;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic wait_drained(string req);
    int n = 0;
    while ((exp_q.size() != 0 || card_sel) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    logic [7:0] held;
    int base;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #5;
    // R1 reset state
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(card_sel == 1'b0, "R1 card_sel", card_sel, 0);
    check(ovf_count == '0, "R1 ovf_count", ovf_count, 0);
    repeat (3) @(negedge clk);

    // R2 R4 R9: random stereo stream, random writer stalls and card busy
    for (int i = 0; i < 300; i++) send($urandom, $urandom % 8);
    pulse_flush();
    wait_drained("R9 stereo flush drained");
    check((out_cnt % BLK) == 0, "R4 whole blocks", out_cnt % BLK, 0);

    // R3 R10: mono stream, mode change requested while partly filled
    stereo_mode = 1'b0;
    repeat (5) @(negedge clk);
    model_mode = 1'b0;
    for (int i = 0; i < 100; i++) send($urandom, $urandom % 6);
    stereo_mode = 1'b1;  // R10: must be ignored while data is buffered
    for (int i = 0; i < 50; i++) send($urandom, $urandom % 6);
    pulse_flush();
    wait_drained("R10 mono kept until empty");
    repeat (5) @(negedge clk);
    model_mode = 1'b1;  // R10: adopted once empty
    for (int i = 0; i < 10; i++) send($urandom, 1);
    pulse_flush();
    wait_drained("R10 stereo adopted when empty");

    // R9: flush with nothing buffered does nothing
    base = out_cnt;
    pulse_flush();
    repeat (30) @(negedge clk);
    #5;
    check(out_cnt == base, "R9 empty flush no block", out_cnt, base);
    check(card_sel == 1'b0, "R9 empty flush card_sel", card_sel, 0);
    check(in_ready == 1'b1, "R9 in_ready after empty flush", in_ready, 1);

    // R6 R8: card busy, fill both banks, then discard three words
    man_busy  = 1'b1;
    man_ready = 1'b0;
    sink_rand = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++) send($urandom, 0);
    repeat (10) @(negedge clk);
    #5;
    check(card_sel == 1'b0, "R6 no start while busy", card_sel, 0);
    check(out_valid == 1'b0, "R6 no byte while busy", out_valid, 0);
    model_drop = 1'b1;
    for (int i = 0; i < 3; i++) send($urandom, 0);
    model_drop = 1'b0;
    repeat (2) @(negedge clk);
    #5;
    check(ovf_count == 3, "R8 overflow count", ovf_count, 3);

    // R5 R7: start the block with the writer stalled
    man_busy = 1'b0;
    while (!card_sel) @(negedge clk);
    repeat (3) @(negedge clk);
    #5;
    check(out_valid == 1'b1, "R7 first byte shown", out_valid, 1);
    check(out_sof == 1'b1, "R4 sof on first byte", out_sof, 1);
    held = out_data;
    repeat (5) @(negedge clk);
    #5;
    check(out_data == held, "R7 data held in stall", out_data, held);
    check(card_sel == 1'b1, "R5 sel held in stall", card_sel, 1);
    // R6: busy raised during a block has no effect on it, but gates the next
    man_busy  = 1'b1;
    man_ready = 1'b1;
    while (card_sel) @(negedge clk);
    repeat (10) @(negedge clk);
    #5;
    check(card_sel == 1'b0, "R6 next block waits on busy", card_sel, 0);
    check(exp_q.size() == BLK, "R6 first block complete", exp_q.size(), BLK);
    man_busy = 1'b0;
    wait_drained("R8 kept blocks drained");
    check(ovf_count == 3, "R8 overflow sticky", ovf_count, 3);

    done = 1'b1;
    finish_run();
  end

endmodule